// File: doc/BRIEF.md
# Unaligned Vector Store Merge Unit

This unit writes a run of 64-byte vectors to a destination byte address that may sit anywhere inside a 64-byte memory row. Memory accepts only whole aligned rows with per-byte enables. A single vector aimed at an unaligned address therefore straddles two rows. The unit holds a carry register with the misalignment offset and the bytes that spill over into the next row. With that state, every incoming vector produces exactly one aligned row write.

Software drives three operations. A prime takes the destination base, records its low six bits as the offset and empties the carry; it writes nothing. A stream takes one vector and builds a row from two sources: the carry fills the low `off` bytes, and the vector, shifted up by `off` byte lanes, fills the rest. The row is written to the aligned row address with all enables set. The vector's top `off` bytes become the new carry, and the base is advanced by the stride. A flush ends the span: it writes only the residual carry bytes with a partial enable mask, and leaves the base alone. A span that is not flushed loses its tail.

Every operation is registered. The write for a command appears on the write port one cycle after the command is accepted. The carry is passed straight to the next command, so dependent steps can issue on back-to-back cycles without stalls.

Top module: `ustore_merge`

## Requirements
- R1: A prime (op code 1) loads the base register from `base_i`, takes offset = `base_i` AND 63, clears the carry, and produces no write on the following cycle.
- R2: For a stream (op code 2), byte i of the written row is carry byte i when i < off, and vector byte i−off otherwise. Byte i is bits [8i+7:8i].
- R3: Each write appears one cycle after its command, at the current base with its low 6 bits cleared.
- R4: A stream write asserts all 64 byte enables.
- R5: After a stream, the carry holds vector bytes 64−off to 63 in its byte lanes 0 to off−1. All other carry bytes are zero.
- R6: A stream adds `stride_i` to the base after the write. A flush leaves the base unchanged. The current base is shown on `base_o`.
- R7: A flush (op code 3) writes the carry bytes with only enables 0 to off−1 asserted, ignores `vec_i`, and leaves the carry empty.
- R8: With offset 0, a stream writes the input vector unchanged and leaves an empty carry, and a following flush asserts no byte enable.
- R9: After reset and before any prime, streams behave as offset 0 with an empty carry, starting from base 0.
- R10: Stream and flush commands on consecutive cycles each use the carry left by the command just before them, with no stall cycle.
- R11: An idle command (op code 0) produces no write and leaves the base and carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Command: 0 idle, 1 prime, 2 stream, 3 flush |
| vec_i | input | 512 | Source vector for a stream |
| base_i | input | 32 | Destination byte address for a prime |
| stride_i | input | 32 | Post-increment added to the base by a stream |
| wr_en_o | output | 1 | Row write valid |
| wr_addr_o | output | 32 | Aligned row byte address |
| wr_data_o | output | 512 | Row data |
| wr_be_o | output | 64 | Per-byte write enables |
| base_o | output | 32 | Current base register |

## Verification
The registered write of a flush that closes one span reaches the write port in the same cycle that a prime for the next span is accepted and overwrites the offset and carry. The bench issues that prime on the cycle right after the flush. It checks that the visible write carries the old span's residual bytes under the old offset's partial enables. It then checks that the next stream uses the new offset with an empty carry. Streams issued on back-to-back cycles provoke the same overlap between a write leaving the unit and the carry being consumed.

// File: rtl/um_pkg.sv
package um_pkg;
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_PRIME  = 2'd1,
        OP_STREAM = 2'd2,
        OP_FLUSH  = 2'd3
    } op_e;
endpackage

// File: rtl/um_row_merge.sv
module um_row_merge #(
    parameter int VEC_BYTES = 64,
    localparam int DATA_W = VEC_BYTES * 8,
    localparam int OFF_W  = $clog2(VEC_BYTES)
) (
    input  logic [DATA_W-1:0]    vec_i,
    input  logic [DATA_W-1:0]    carry_i,
    input  logic [OFF_W-1:0]     off_i,
    input  logic                 flush_i,
    output logic [DATA_W-1:0]    row_o,
    output logic [VEC_BYTES-1:0] be_o,
    output logic [DATA_W-1:0]    carry_o
);
    logic [VEC_BYTES-1:0] low_bytes;
    logic [DATA_W-1:0]    low_bits;
    logic [DATA_W-1:0]    vec_eff;
    logic [OFF_W:0]       rem_bytes;
    logic [OFF_W+3:0]     sh_up;
    logic [OFF_W+3:0]     sh_down;

    // byte lanes below the offset belong to the carry
    assign low_bytes = ~({VEC_BYTES{1'b1}} << off_i);

    for (genvar b = 0; b < VEC_BYTES; b++) begin : g_lane_mask
        assign low_bits[8*b +: 8] = {8{low_bytes[b]}};
    end

    assign vec_eff   = flush_i ? '0 : vec_i;
    assign rem_bytes = (OFF_W+1)'(VEC_BYTES) - {1'b0, off_i};
    assign sh_up     = {1'b0, off_i, 3'b000};
    assign sh_down   = {rem_bytes, 3'b000};

    always_comb begin
        row_o   = (vec_eff << sh_up) | (carry_i & low_bits);
        carry_o = vec_eff >> sh_down;
        be_o    = flush_i ? low_bytes : {VEC_BYTES{1'b1}};
    end
endmodule

// File: rtl/um_agu.sv
module um_agu
    import um_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  op_e               op_i,
    input  logic [ADDR_W-1:0] base_q_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    output logic [ADDR_W-1:0] base_d_o
);
    always_comb begin
        case (op_i)
            OP_PRIME:  base_d_o = base_i;
            OP_STREAM: base_d_o = base_q_i + stride_i;
            default:   base_d_o = base_q_i;
        endcase
    end
endmodule

// File: rtl/ustore_merge.sv
module ustore_merge
    import um_pkg::*;
#(
    parameter int VEC_BYTES = 64,
    parameter int ADDR_W    = 32,
    localparam int DATA_W = VEC_BYTES * 8,
    localparam int OFF_W  = $clog2(VEC_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           op_i,
    input  logic [DATA_W-1:0]    vec_i,
    input  logic [ADDR_W-1:0]    base_i,
    input  logic [ADDR_W-1:0]    stride_i,
    output logic                 wr_en_o,
    output logic [ADDR_W-1:0]    wr_addr_o,
    output logic [DATA_W-1:0]    wr_data_o,
    output logic [VEC_BYTES-1:0] wr_be_o,
    output logic [ADDR_W-1:0]    base_o
);
    typedef struct packed {
        logic [ADDR_W-1:0]    base;
        logic [OFF_W-1:0]     off;
        logic [DATA_W-1:0]    carry;
        logic                 wr_en;
        logic [ADDR_W-1:0]    wr_addr;
        logic [DATA_W-1:0]    wr_data;
        logic [VEC_BYTES-1:0] wr_be;
    } state_t;

    state_t st_d, st_q;
    op_e    op;

    logic [DATA_W-1:0]    row;
    logic [VEC_BYTES-1:0] row_be;
    logic [DATA_W-1:0]    carry_nx;
    logic [ADDR_W-1:0]    base_nx;

    assign op = op_e'(op_i);

    um_row_merge #(.VEC_BYTES(VEC_BYTES)) i_merge (
        .vec_i   (vec_i),
        .carry_i (st_q.carry),
        .off_i   (st_q.off),
        .flush_i (op == OP_FLUSH),
        .row_o   (row),
        .be_o    (row_be),
        .carry_o (carry_nx)
    );

    um_agu #(.ADDR_W(ADDR_W)) i_agu (
        .op_i     (op),
        .base_q_i (st_q.base),
        .base_i   (base_i),
        .stride_i (stride_i),
        .base_d_o (base_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.base  = base_nx;
        case (op)
            OP_PRIME: begin
                st_d.off   = base_i[OFF_W-1:0];
                st_d.carry = '0;
            end
            OP_STREAM, OP_FLUSH: begin
                st_d.wr_en   = 1'b1;
                st_d.wr_addr = {st_q.base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                st_d.wr_data = row;
                st_d.wr_be   = row_be;
                st_d.carry   = carry_nx;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en_o   = st_q.wr_en;
    assign wr_addr_o = st_q.wr_addr;
    assign wr_data_o = st_q.wr_data;
    assign wr_be_o   = st_q.wr_be;
    assign base_o    = st_q.base;

    assert_prime_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PRIME) |=> !wr_en_o);

    assert_row_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o[OFF_W-1:0] == '0));

    assert_stream_full_be_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STREAM) |=> (wr_en_o && (&wr_be_o)));

    assert_base_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STREAM) |=> (base_o == $past(base_o) + $past(stride_i)));

    assert_flush_base_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLUSH) |=> $stable(base_o));

    assert_flush_tail_be_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLUSH) |=> (($countones(wr_be_o) == 32'($past(st_q.off)))
                              && ((wr_be_o & (wr_be_o + 1'b1)) == '0)));

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLUSH) |=> (st_q.carry == '0));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |=> (!wr_en_o && $stable(base_o) && $stable(st_q.carry)));
endmodule

// File: tb/test_ustore_merge.sv
`timescale 1ns/1ps
module test_ustore_merge;
    localparam int VB = 64;
    localparam int DW = VB * 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    op_i;
    logic [DW-1:0] vec_i;
    logic [31:0]   base_i;
    logic [31:0]   stride_i;
    logic          wr_en_o;
    logic [31:0]   wr_addr_o;
    logic [DW-1:0] wr_data_o;
    logic [VB-1:0] wr_be_o;
    logic [31:0]   base_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench-side reference state
    logic [DW-1:0] m_carry;
    int            m_off;
    logic [31:0]   m_base;

    always #2.5 clk = ~clk;

    ustore_merge i_ustore_merge (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .vec_i(vec_i), .base_i(base_i),
        .stride_i(stride_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .wr_be_o(wr_be_o), .base_o(base_o)
    );

    function automatic logic [DW-1:0] pat(input int seed);
        logic [DW-1:0] v;
        for (int b = 0; b < VB; b++) v[8*b +: 8] = 8'((seed * 29 + b * 7 + 1) & 255);
        return v;
    endfunction

    task automatic chk(input string req, input string what, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // drive one command on a falling edge, observe its registered result one cycle later
    task automatic step(input logic [1:0] op, input logic [DW-1:0] v, input logic [31:0] b,
                        input logic [31:0] s, input string req);
        logic [DW-1:0] e_row;
        logic [DW-1:0] e_carry;
        logic [VB-1:0] e_be;
        logic [31:0]   e_addr;
        logic [31:0]   e_base;
        logic          e_wr;
        logic [DW-1:0] v_eff;
        op_i = op; vec_i = v; base_i = b; stride_i = s;
        v_eff  = (op == 2'd3) ? '0 : v;
        e_row  = '0; e_carry = m_carry; e_be = '0;
        e_addr = {m_base[31:6], 6'd0};
        e_base = m_base;
        e_wr   = (op == 2'd2) || (op == 2'd3);
        if (e_wr) begin
            e_carry = '0;
            for (int i = 0; i < VB; i++) begin
                if (i < m_off) e_row[8*i +: 8] = m_carry[8*i +: 8];
                else           e_row[8*i +: 8] = v_eff[8*(i-m_off) +: 8];
                e_be[i] = (op == 2'd2) || (i < m_off);
            end
            for (int j = 0; j < m_off; j++) e_carry[8*j +: 8] = v_eff[8*(VB-m_off+j) +: 8];
            if (op == 2'd2) e_base = m_base + s;
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, "wr_en", DW'(wr_en_o), DW'(e_wr));
        if (e_wr) begin
            chk(req, "row data", wr_data_o, e_row);
            chk(req, "byte enables", DW'(wr_be_o), DW'(e_be));
            chk(req, "row address", DW'(wr_addr_o), DW'(e_addr));
        end
        if (op == 2'd1) begin
            m_off = int'(b[5:0]); m_carry = '0; e_base = b;
        end else begin
            m_carry = e_carry;
        end
        m_base = e_base;
        chk(req, "base", DW'(base_o), DW'(m_base));
        op_i = 2'd0;
    endtask

    task automatic t_reset;
        chk("R9", "reset wr_en", DW'(wr_en_o), '0);
        chk("R9", "reset base", DW'(base_o), '0);
    endtask

    task automatic t_unprimed;   // R9: offset 0, empty carry before any prime
        step(2'd2, pat(1), 32'd0, 32'd64, "R9");
        chk("R9", "row equals vector", wr_data_o, pat(1));
        step(2'd3, '0, 32'd0, 32'd0, "R9");
        chk("R9", "flush no enables", DW'(wr_be_o), '0);
    endtask

    task automatic t_idle;       // R11
        step(2'd0, pat(9), 32'd77, 32'd5, "R11");
        step(2'd0, pat(3), 32'd1, 32'd1, "R11");
    endtask

    task automatic t_aligned;    // R8, R1
        step(2'd1, pat(4), 32'h0000_2000, 32'd0, "R1");
        step(2'd2, pat(5), 32'd0, 32'd64, "R8");
        chk("R8", "aligned row", wr_data_o, pat(5));
        step(2'd3, pat(6), 32'd0, 32'd0, "R8");
        chk("R8", "aligned flush be", DW'(wr_be_o), '0);
    endtask

    task automatic t_span5;      // R2 R4 R5 R10 R7: back-to-back streams at offset 5
        step(2'd1, '0, 32'h0000_1005, 32'd0, "R1");
        step(2'd2, pat(11), 32'd0, 32'd64, "R2");
        step(2'd2, pat(12), 32'd0, 32'd64, "R10");
        step(2'd2, pat(13), 32'd0, 32'd128, "R5");
        step(2'd3, pat(14), 32'd0, 32'd0, "R7");
        chk("R7", "tail enables", DW'(wr_be_o), DW'(64'h1F));
        chk("R4", "tail address", DW'(wr_addr_o), DW'(32'h0000_1100));
    endtask

    task automatic t_span63_then_prime;   // R7 flush overlapping next prime, R1
        step(2'd1, '0, 32'h0000_3FFF, 32'd0, "R1");
        step(2'd2, pat(21), 32'd0, 32'd64, "R2");
        step(2'd2, pat(22), 32'd0, 32'd64, "R10");
        op_i = 2'd3; vec_i = pat(23); stride_i = '0;
        begin
            logic [DW-1:0] e_tail;
            e_tail = '0;
            for (int i = 0; i < 63; i++) e_tail[8*i +: 8] = m_carry[8*i +: 8];
            @(posedge clk);
            @(negedge clk);
            chk("R7", "flush wr_en", DW'(wr_en_o), DW'(1'b1));
            chk("R7", "flush tail data", wr_data_o, e_tail);
            chk("R7", "flush enables", DW'(wr_be_o), DW'({1'b0, {63{1'b1}}}));
            m_carry = '0;
        end
        step(2'd1, '0, 32'h0000_4012, 32'd0, "R1");
        step(2'd2, pat(24), 32'd0, 32'd64, "R1");
        step(2'd3, '0, 32'd0, 32'd0, "R7");
    endtask

    initial begin
        rst_n = 1'b0; op_i = '0; vec_i = '0; base_i = '0; stride_i = '0;
        m_carry = '0; m_off = 0; m_base = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unprimed();
        t_idle();
        t_aligned();
        t_span5();
        t_span63_then_prime();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule